// File: doc/BRIEF.md
# Reset Cause Flag Register

This block holds one sticky flag for each kind of reset that can strike the chip. The five causes are an external pin reset, a watchdog reset, a power-on or low-voltage reset, a hardware reset and a software reset. Each cause has a one-cycle event input. An event sets its flag. An event of a different kind leaves the flag as it was. The one exception is the power-on or low-voltage event, which loads a defined state. The block does not generate any reset, does not watch the supply, and does not sequence the system reset. It only remembers which reset happened.

Firmware reads the register through a small register bus. The bus has a select, a read strobe, a write strobe and an 8-bit write data port. Every access clears all five flags, whether it is a read or a write, and whatever value is written.

An access is accepted in the cycle where select and a strobe are both high. An access finite-state machine tracks it with three states:
- `ACC_IDLE`: no access.
- `ACC_READ`: the previous cycle held a read.
- `ACC_WRITE`: the previous cycle held a write.

The state moves to `ACC_READ` when select and read are high, and to `ACC_WRITE` when select and write are high without read. Any other cycle returns it to `ACC_IDLE`, and any state may move straight to any other. Read data appears in the cycle spent in `ACC_READ`. It holds the flags as they were before the clear. The asynchronous power-up reset input places the machine in `ACC_IDLE` and loads the power-on state into the flags.

Top module: `rst_cause_reg`

## Requirements
- R1: While `arst_n` is low the flags take the power-on state, and the first read after release returns 0x04.
- R2: Read data bits 7 to 5 are always 0.
- R3: One cycle after an event pulse, its flag is 1. The flag positions in read data are: external bit 4, watchdog bit 3, power-on/low-voltage bit 2, hardware bit 1, software bit 0.
- R4: A flag keeps its value across cycles with no access, no event of its own kind and no power-on event, including across events of other kinds.
- R5: After a read access in cycle N, `rdata` in cycle N+1 shows the flags as they stood during cycle N. From cycle N+1 onwards, all flags are 0 unless an event occurred in cycle N.
- R6: A write access clears all flags, whatever the value of `wdata`. Nothing from `wdata` is stored.
- R7: When an event and an access fall in the same cycle, the event wins and that flag is 1 afterwards.
- R8: A power-on/low-voltage event sets bit 2 and clears every other flag, except a flag whose own event comes in the same cycle.
- R9: `rdata` is 0 in every cycle that does not follow a read access.
- R10: Read or write strobes with `sel` low have no effect on the flags or on `rdata`.
- R11: When select, read and write are all high, the access counts as a read: data is returned and the flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| evt_ext | input | 1 | External pin reset event pulse |
| evt_wdt | input | 1 | Watchdog reset event pulse |
| evt_pwr | input | 1 | Power-on or low-voltage reset event pulse |
| evt_hw | input | 1 | Hardware reset event pulse |
| evt_sw | input | 1 | Software reset event pulse |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data (its value is ignored) |
| rdata | output | 8 | Read data, valid in the cycle after a read |

## Verification
A reset event and a clearing bus access can land in the same cycle. Whether the event or the clear wins decides if the cause survives.

The bench provokes this case in two ways. Directed cycles pair a watchdog event with a read, and a power-on event with a software event. Random cycles then drive events and accesses independently, so collisions happen often.

Each result is judged against a bench model in which the clear is applied first and the events are ORed in afterwards. The read returned in the collision cycle must show the flags from before the event. The following read must show the surviving flag.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    localparam int RCF_DATA_W    = 8;
    localparam int RCF_NUM_CAUSE = 5;
    localparam int RCF_PWR_IDX   = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;
endpackage

// File: rtl/rcf_flag_cell.sv
module rcf_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic load_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q_o <= RST_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i || load_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rcf_acc_fsm.sv
module rcf_acc_fsm
    import rcf_pkg::*;
#(
    parameter int NUM_CAUSE = RCF_NUM_CAUSE,
    parameter int DATA_W    = RCF_DATA_W
) (
    input  logic                 clk,
    input  logic                 arst_n,
    input  logic                 sel,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [NUM_CAUSE-1:0] flags_i,
    output logic                 clr_o,
    output logic [DATA_W-1:0]    rdata_o
);
    acc_state_t state_q, state_d;
    logic [NUM_CAUSE-1:0] snap_q;
    logic acc_rd, acc_wr;

    assign acc_rd = sel && rd;
    assign acc_wr = sel && wr && !rd;
    assign clr_o  = acc_rd || acc_wr;

    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_READ, ACC_WRITE: begin
                if (acc_rd)      state_d = ACC_READ;
                else if (acc_wr) state_d = ACC_WRITE;
                else             state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ACC_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     snap_q <= '0;
        else if (acc_rd) snap_q <= flags_i;
    end

    always_comb begin
        rdata_o = '0;
        unique case (state_q)
            ACC_READ:           rdata_o = DATA_W'(snap_q);
            ACC_IDLE, ACC_WRITE: rdata_o = '0;
            default:            rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcf_pkg::*;
#(
    parameter int NUM_CAUSE = RCF_NUM_CAUSE,
    parameter int DATA_W    = RCF_DATA_W,
    parameter int PWR_IDX   = RCF_PWR_IDX
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              evt_ext,
    input  logic              evt_wdt,
    input  logic              evt_pwr,
    input  logic              evt_hw,
    input  logic              evt_sw,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_CAUSE-1:0] evt_vec;
    logic [NUM_CAUSE-1:0] flag_q;
    logic                 clr;
    logic                 unused_wdata;

    assign evt_vec      = NUM_CAUSE'({evt_ext, evt_wdt, evt_pwr, evt_hw, evt_sw});
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_flag
        rcf_flag_cell #(
            .RST_VAL(i == PWR_IDX)
        ) u_cell (
            .clk   (clk),
            .arst_n(arst_n),
            .set_i (evt_vec[i]),
            .clr_i (clr),
            .load_i(evt_pwr),
            .q_o   (flag_q[i])
        );
    end

    rcf_acc_fsm #(
        .NUM_CAUSE(NUM_CAUSE),
        .DATA_W   (DATA_W)
    ) u_fsm (
        .clk    (clk),
        .arst_n (arst_n),
        .sel    (sel),
        .rd     (rd),
        .wr     (wr),
        .flags_i(flag_q),
        .clr_o  (clr),
        .rdata_o(rdata)
    );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
    parameter int NUM_CAUSE = 5,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 arst_n,
    input logic                 evt_ext,
    input logic                 evt_wdt,
    input logic                 evt_pwr,
    input logic                 evt_hw,
    input logic                 evt_sw,
    input logic                 sel,
    input logic                 rd,
    input logic                 wr,
    input logic [NUM_CAUSE-1:0] flag_q,
    input logic [DATA_W-1:0]    rdata
);
    logic any_evt;
    assign any_evt = evt_ext || evt_wdt || evt_pwr || evt_hw || evt_sw;

    // R2
    rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rdata[DATA_W-1:NUM_CAUSE] == '0);

    // R3
    ext_sets_flag_chk: assert property (@(posedge clk) disable iff (!arst_n)
        evt_ext |=> flag_q[4]);

    // R7
    wdt_beats_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_wdt && sel && (rd || wr)) |=> flag_q[3]);

    // R5
    read_returns_old_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (sel && rd) |=> rdata == DATA_W'($past(flag_q)));

    // R6
    write_clears_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (sel && wr && !any_evt) |=> flag_q == '0);

    // R8
    pwr_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_pwr && !evt_ext && !evt_wdt && !evt_hw && !evt_sw) |=> flag_q == NUM_CAUSE'(4));

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!(sel && (rd || wr)) && !any_evt) |=> $stable(flag_q));

    // R9
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !(sel && rd) |=> rdata == '0);
endmodule

bind rst_cause_reg rst_cause_chk #(
    .NUM_CAUSE(NUM_CAUSE),
    .DATA_W   (DATA_W)
) u_chk (
    .clk    (clk),
    .arst_n (arst_n),
    .evt_ext(evt_ext),
    .evt_wdt(evt_wdt),
    .evt_pwr(evt_pwr),
    .evt_hw (evt_hw),
    .evt_sw (evt_sw),
    .sel    (sel),
    .rd     (rd),
    .wr     (wr),
    .flag_q (flag_q),
    .rdata  (rdata)
);

// File: tb/test_rst_cause_reg.sv
`timescale 1ns/1ps
module test_rst_cause_reg;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       evt_ext = 0, evt_wdt = 0, evt_pwr = 0, evt_hw = 0, evt_sw = 0;
    logic       sel = 0, rd = 0, wr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [4:0] model = 5'b00100;

    always #(CLK_NS/2) clk = ~clk;

    rst_cause_reg i_rst_cause_reg (
        .clk(clk), .arst_n(arst_n),
        .evt_ext(evt_ext), .evt_wdt(evt_wdt), .evt_pwr(evt_pwr),
        .evt_hw(evt_hw), .evt_sw(evt_sw),
        .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [4:0] next_flags(input logic [4:0] old, input logic [4:0] ev,
                                              input logic acc);
        logic [4:0] n;
        n = (acc || ev[2]) ? 5'b0 : old;
        return n | ev;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // ev = {ext, wdt, pwr, hw, sw}
    task automatic cyc(input logic [4:0] ev, input logic s, input logic r, input logic w,
                       input logic [7:0] wd, input string tag);
        logic [7:0] exp_rd;
        {evt_ext, evt_wdt, evt_pwr, evt_hw, evt_sw} = ev;
        sel = s; rd = r; wr = w; wdata = wd;
        @(posedge clk);
        exp_rd = (s && r) ? {3'b000, model} : 8'h00;
        model  = next_flags(model, ev, s && (r || w));
        @(negedge clk);
        {evt_ext, evt_wdt, evt_pwr, evt_hw, evt_sw} = '0;
        sel = 0; rd = 0; wr = 0;
        check(tag, rdata, exp_rd);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R9 reset idle", rdata, 8'h00);
        arst_n = 1'b1;
        @(negedge clk);
        cyc(5'b0, 1, 1, 0, 8'h00, "R1 power-up read");
        cyc(5'b0, 1, 1, 0, 8'h00, "R5 cleared after read");
        cyc(5'b0, 0, 0, 0, 8'h00, "R9 idle");
        // R3 each event, then read
        for (int i = 0; i < 5; i++) begin
            cyc(5'(1 << i), 0, 0, 0, 8'h00, "R3 event");
            cyc(5'b0, 1, 1, 0, 8'h00, "R3 flag position");
        end
        // R4 persistence across other kinds
        cyc(5'b10000, 0, 0, 0, 8'h00, "R4 ext");
        cyc(5'b01000, 0, 0, 0, 8'h00, "R4 wdt");
        cyc(5'b00010, 0, 0, 0, 8'h00, "R4 hw");
        cyc(5'b0, 1, 1, 0, 8'h00, "R4 keep 0x1a");
        // R6 write ignores data
        cyc(5'b10001, 0, 0, 0, 8'h00, "R6 set");
        cyc(5'b0, 1, 0, 1, 8'hFF, "R6 write ff");
        cyc(5'b0, 1, 1, 0, 8'h00, "R6 R2 after write");
        // R7 event with read
        cyc(5'b10000, 0, 0, 0, 8'h00, "R7 set");
        cyc(5'b01000, 1, 1, 0, 8'h00, "R7 read old");
        cyc(5'b0, 1, 1, 0, 8'h00, "R7 survivor");
        cyc(5'b00001, 1, 0, 1, 8'h00, "R7 write with event");
        cyc(5'b0, 1, 1, 0, 8'h00, "R7 survivor write");
        // R8 power load
        cyc(5'b11010, 0, 0, 0, 8'h00, "R8 set");
        cyc(5'b00100, 0, 0, 0, 8'h00, "R8 pwr");
        cyc(5'b0, 1, 1, 0, 8'h00, "R8 load 0x04");
        cyc(5'b00101, 0, 0, 0, 8'h00, "R8 pwr+sw");
        cyc(5'b0, 1, 1, 0, 8'h00, "R8 load 0x05");
        // R10 strobes without select
        cyc(5'b01000, 0, 0, 0, 8'h00, "R10 set");
        cyc(5'b0, 0, 1, 0, 8'h00, "R10 rd no sel");
        cyc(5'b0, 0, 0, 1, 8'h55, "R10 wr no sel");
        cyc(5'b0, 1, 1, 0, 8'h00, "R10 kept");
        // R11 read and write together
        cyc(5'b00010, 0, 0, 0, 8'h00, "R11 set");
        cyc(5'b0, 1, 1, 1, 8'hAA, "R11 rd+wr returns");
        cyc(5'b0, 1, 1, 0, 8'h00, "R11 cleared");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] ev;
            for (int b = 0; b < 5; b++) ev[b] = (($urandom % 8) == 0);
            cyc(ev, ($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                8'($urandom), "R4 R7 random");
        end
        done = 1;
        summary();
        $finish;
    end
endmodule